// File: doc/BRIEF.md
# TDM Synchronous Transfer Engine

This block bridges single samples between time-slot memories of a TDM switch. It has a small number of independent transfer channels, two by default. Each channel holds a source address, a destination address, a control word and one sample buffer. Once per frame, when the frame position reaches the slot named by the source address, the channel reads that memory location into its buffer. When the position reaches the slot named by the destination address, it writes the buffer back out. Each address carries an interface select bit (PCM or configurable interface), a port number and a time-slot number. Any pair of locations can therefore be joined. This covers PCM to PCM loops, a configurable-interface channel looped back onto itself, and crossings between the two interfaces.

A host processor reaches every channel register through a small word-wide bus. The host can watch the sample in flight, replace it, or change the routing. A sticky flag tells the host that a new sample has landed since it last read the buffer. A channel can also be limited to a single 2-bit sub-slot field of the sample. In that mode only that field is captured, and the write carries a matching byte mask. The switching memories sit outside the block, behind per-channel strobe, address and data ports.

Top module: `sxf_top`

## Requirements
- R1: After reset, every channel register (buffer, source, destination, control, flag) reads 0, and no read or write strobe is issued.
- R2: An address is {interface bit 7, port bits 6:5, slot bits 4:0}. A strobe fires on a match of bits 4:0 with `slot_i`. `rd_addr_o`/`wr_addr_o` carry the full stored source/destination address, and they change only after a host write.
- R3: When a channel is enabled (control bit 0) and `tick_i` is high with `slot_i` equal to the source slot, `rd_en_o` is high in that cycle. The buffer takes `rd_data_i` at the following edge.
- R4: When a channel is enabled and `tick_i` is high with `slot_i` equal to the destination slot, `wr_en_o` is high in that cycle. `wr_data_o` is the buffer value from before any capture in that same cycle, and `wr_mask_o` is 0xFF when no restriction is set.
- R5: With control bit 1 set, the sub-slot index in control bits 3:2 selects the field at bits [2*idx+1:2*idx]. A capture replaces only that field, and `wr_mask_o` has only that field set.
- R6: A disabled channel issues no strobes, and its buffer keeps its value.
- R7: Channels are independent. Both may strobe in the same cycle, and each captures its own `rd_data_i` lane.
- R8: Host address is {channel, register}, with register 0 buffer, 1 source, 2 destination, 3 control. Written values read back. Control reads return {flag, 3'b000, bits 3:0}.
- R9: A host write to a buffer in the cycle of that channel's capture is discarded, and the captured sample is kept.
- R10: The flag (control read bit 7) is set by a capture. It is cleared by `cpu_re_i` addressing that channel's buffer, unless a capture occurs in the same cycle.
- R11: No strobe is issued while `tick_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Slot position valid this cycle |
| slot_i | input | 5 | Current time-slot number |
| cpu_addr_i | input | 3 | Host register address {channel, register} |
| cpu_we_i | input | 1 | Host write strobe |
| cpu_re_i | input | 1 | Host read strobe (clears flag on buffer read) |
| cpu_wdata_i | input | 8 | Host write data |
| cpu_rdata_o | output | 8 | Host read data (combinational) |
| rd_en_o | output | 2 | Per-channel memory read strobe |
| rd_addr_o | output | 16 | Per-channel source address, 8 bits per lane |
| rd_data_i | input | 16 | Per-channel memory read data, same cycle |
| wr_en_o | output | 2 | Per-channel memory write strobe |
| wr_addr_o | output | 16 | Per-channel destination address |
| wr_data_o | output | 16 | Per-channel write data (buffer) |
| wr_mask_o | output | 16 | Per-channel write bit mask |

## Verification
The bench builds the block with its defaults: two channels, 8-bit samples, 2-bit sub-slot fields and a 5-bit slot number. With two channels, simultaneous strobes on both lanes and cross-channel host addressing can be reached. With four sub-slot fields, every mask position is reachable from a random control word. The random phase confines stored slots and `slot_i` mostly to slots 0 to 3. This makes source/destination hits, same-slot read/write pairs and capture/host collisions frequent.

// File: rtl/sxf_pkg.sv
package sxf_pkg;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_SRC  = 2'd1,
        REG_DST  = 2'd2,
        REG_CTL  = 2'd3
    } sxf_reg_e;

    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_RESTR_BIT = 1;
    localparam int CTL_SEL_LSB   = 2;

endpackage

// File: rtl/sxf_match.sv
module sxf_match #(
    parameter int SLOT_W = 5
) (
    input  logic              tick_i,
    input  logic              en_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [SLOT_W-1:0] want_i,
    output logic              hit_o
);

    always_comb begin
        hit_o = tick_i && en_i && (want_i == slot_i);
    end

endmodule

// File: rtl/sxf_chan.sv
module sxf_chan
    import sxf_pkg::*;
#(
    parameter int DW       = 8,
    parameter int AW       = 8,
    parameter int SLOT_W   = 5,
    parameter int SUB_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              cpu_we_i,
    input  logic              cpu_re_i,
    input  sxf_reg_e          cpu_reg_i,
    input  logic [DW-1:0]     cpu_wdata_i,
    output logic [DW-1:0]     cpu_rdata_o,
    output logic              rd_en_o,
    output logic [AW-1:0]     rd_addr_o,
    input  logic [DW-1:0]     rd_data_i,
    output logic              wr_en_o,
    output logic [AW-1:0]     wr_addr_o,
    output logic [DW-1:0]     wr_data_o,
    output logic [DW-1:0]     wr_mask_o
);

    localparam int NSUB  = DW / SUB_BITS;
    localparam int SEL_W = (NSUB > 1) ? $clog2(NSUB) : 1;
    localparam logic [DW-1:0] FIELD = DW'((1 << SUB_BITS) - 1);

    typedef struct packed {
        logic             en;
        logic             restr;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    typedef struct packed {
        logic [DW-1:0] data;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        ctl_t          ctl;
        logic          flag;
    } chan_t;

    chan_t st_d, st_q;
    logic  rd_hit, wr_hit;
    logic [DW-1:0] mask;

    sxf_match #(.SLOT_W(SLOT_W)) u_rd_match (
        .tick_i (tick_i),
        .en_i   (st_q.ctl.en),
        .slot_i (slot_i),
        .want_i (st_q.src[SLOT_W-1:0]),
        .hit_o  (rd_hit)
    );

    sxf_match #(.SLOT_W(SLOT_W)) u_wr_match (
        .tick_i (tick_i),
        .en_i   (st_q.ctl.en),
        .slot_i (slot_i),
        .want_i (st_q.dst[SLOT_W-1:0]),
        .hit_o  (wr_hit)
    );

    always_comb begin
        st_d = st_q;
        mask = st_q.ctl.restr ? (FIELD << (SUB_BITS * int'(st_q.ctl.sel))) : '1;

        if (cpu_we_i) begin
            case (cpu_reg_i)
                REG_DATA: st_d.data = cpu_wdata_i;
                REG_SRC:  st_d.src  = cpu_wdata_i[AW-1:0];
                REG_DST:  st_d.dst  = cpu_wdata_i[AW-1:0];
                default: begin
                    st_d.ctl.en    = cpu_wdata_i[CTL_EN_BIT];
                    st_d.ctl.restr = cpu_wdata_i[CTL_RESTR_BIT];
                    st_d.ctl.sel   = cpu_wdata_i[CTL_SEL_LSB +: SEL_W];
                end
            endcase
        end
        if (cpu_re_i && cpu_reg_i == REG_DATA) begin
            st_d.flag = 1'b0;
        end
        // hardware capture overrides any host buffer write or flag clear
        if (rd_hit) begin
            st_d.data = (st_q.data & ~mask) | (rd_data_i & mask);
            st_d.flag = 1'b1;
        end

        cpu_rdata_o = '0;
        case (cpu_reg_i)
            REG_DATA: cpu_rdata_o = st_q.data;
            REG_SRC:  cpu_rdata_o[AW-1:0] = st_q.src;
            REG_DST:  cpu_rdata_o[AW-1:0] = st_q.dst;
            default: begin
                cpu_rdata_o[CTL_EN_BIT]            = st_q.ctl.en;
                cpu_rdata_o[CTL_RESTR_BIT]         = st_q.ctl.restr;
                cpu_rdata_o[CTL_SEL_LSB +: SEL_W]  = st_q.ctl.sel;
                cpu_rdata_o[DW-1]                  = st_q.flag;
            end
        endcase

        rd_en_o   = rd_hit;
        rd_addr_o = st_q.src;
        wr_en_o   = wr_hit;
        wr_addr_o = st_q.dst;
        wr_data_o = st_q.data;
        wr_mask_o = mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sxf_top.sv
module sxf_top
    import sxf_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int DW       = 8,
    parameter int PORT_W   = 2,
    parameter int SLOT_W   = 5,
    parameter int SUB_BITS = 2,
    localparam int AW      = 1 + PORT_W + SLOT_W,
    localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CA_W    = CH_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [CA_W-1:0]   cpu_addr_i,
    input  logic              cpu_we_i,
    input  logic              cpu_re_i,
    input  logic [DW-1:0]     cpu_wdata_i,
    output logic [DW-1:0]     cpu_rdata_o,
    output logic [NCH-1:0]    rd_en_o,
    output logic [NCH*AW-1:0] rd_addr_o,
    input  logic [NCH*DW-1:0] rd_data_i,
    output logic [NCH-1:0]    wr_en_o,
    output logic [NCH*AW-1:0] wr_addr_o,
    output logic [NCH*DW-1:0] wr_data_o,
    output logic [NCH*DW-1:0] wr_mask_o
);

    logic [DW-1:0] ch_rdata [NCH];
    sxf_reg_e      reg_sel;
    logic [CH_W-1:0] ch_sel;

    always_comb begin
        reg_sel = sxf_reg_e'(cpu_addr_i[1:0]);
        ch_sel  = cpu_addr_i[CA_W-1:2];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic pick;
        always_comb pick = (ch_sel == CH_W'(c));

        sxf_chan #(
            .DW(DW), .AW(AW), .SLOT_W(SLOT_W), .SUB_BITS(SUB_BITS)
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick_i      (tick_i),
            .slot_i      (slot_i),
            .cpu_we_i    (cpu_we_i && pick),
            .cpu_re_i    (cpu_re_i && pick),
            .cpu_reg_i   (reg_sel),
            .cpu_wdata_i (cpu_wdata_i),
            .cpu_rdata_o (ch_rdata[c]),
            .rd_en_o     (rd_en_o[c]),
            .rd_addr_o   (rd_addr_o[c*AW +: AW]),
            .rd_data_i   (rd_data_i[c*DW +: DW]),
            .wr_en_o     (wr_en_o[c]),
            .wr_addr_o   (wr_addr_o[c*AW +: AW]),
            .wr_data_o   (wr_data_o[c*DW +: DW]),
            .wr_mask_o   (wr_mask_o[c*DW +: DW])
        );
    end

    always_comb begin
        cpu_rdata_o = '0;
        for (int c = 0; c < NCH; c++) begin
            if (ch_sel == CH_W'(c)) cpu_rdata_o = ch_rdata[c];
        end
    end

endmodule

// File: rtl/sxf_chk.sv
module sxf_chk #(
    parameter int NCH      = 2,
    parameter int DW       = 8,
    parameter int AW       = 8,
    parameter int SLOT_W   = 5,
    parameter int SUB_BITS = 2,
    parameter int CH_W     = 1,
    parameter int CA_W     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic [SLOT_W-1:0] slot_i,
    input logic [CA_W-1:0]   cpu_addr_i,
    input logic              cpu_we_i,
    input logic [DW-1:0]     cpu_wdata_i,
    input logic [DW-1:0]     cpu_rdata_o,
    input logic [NCH-1:0]    rd_en_o,
    input logic [NCH*AW-1:0] rd_addr_o,
    input logic [NCH-1:0]    wr_en_o,
    input logic [NCH*AW-1:0] wr_addr_o,
    input logic [NCH*DW-1:0] wr_mask_o
);

    // R11
    strobe_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |-> (rd_en_o == '0 && wr_en_o == '0));

    // R2
    rd_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_we_i |=> $stable(rd_addr_o));

    // R2
    wr_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_we_i |=> $stable(wr_addr_o));

    for (genvar c = 0; c < NCH; c++) begin : g_c
        // R3
        rd_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en_o[c] |-> (rd_addr_o[c*AW +: SLOT_W] == slot_i));

        // R4
        wr_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en_o[c] |-> (wr_addr_o[c*AW +: SLOT_W] == slot_i));

        // R5
        wr_mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en_o[c] |-> ($countones(wr_mask_o[c*DW +: DW]) == SUB_BITS
                            || wr_mask_o[c*DW +: DW] == '1));

        // R8
        data_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_we_i && cpu_addr_i[CA_W-1:2] == CH_W'(c) && cpu_addr_i[1:0] == 2'b00
             && !rd_en_o[c])
            ##1 (cpu_addr_i[CA_W-1:2] == CH_W'(c) && cpu_addr_i[1:0] == 2'b00)
            |-> cpu_rdata_o == $past(cpu_wdata_i));
    end

endmodule

bind sxf_top sxf_chk #(
    .NCH(NCH), .DW(DW), .AW(AW), .SLOT_W(SLOT_W), .SUB_BITS(SUB_BITS),
    .CH_W(CH_W), .CA_W(CA_W)
) u_sxf_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .slot_i      (slot_i),
    .cpu_addr_i  (cpu_addr_i),
    .cpu_we_i    (cpu_we_i),
    .cpu_wdata_i (cpu_wdata_i),
    .cpu_rdata_o (cpu_rdata_o),
    .rd_en_o     (rd_en_o),
    .rd_addr_o   (rd_addr_o),
    .wr_en_o     (wr_en_o),
    .wr_addr_o   (wr_addr_o),
    .wr_mask_o   (wr_mask_o)
);

// File: tb/tb_sxf_top.sv
module tb_sxf_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic [4:0]  slot;
    logic [2:0]  cpu_addr;
    logic        cpu_we, cpu_re;
    logic [7:0]  cpu_wdata, cpu_rdata;
    logic [1:0]  rd_en, wr_en;
    logic [15:0] rd_addr, rd_data, wr_addr, wr_data, wr_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_data [2];
    logic [7:0] m_src  [2];
    logic [7:0] m_dst  [2];
    logic [3:0] m_ctl  [2];
    logic       m_flag [2];

    always #10 clk = ~clk;

    sxf_top dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .slot_i(slot),
        .cpu_addr_i(cpu_addr), .cpu_we_i(cpu_we), .cpu_re_i(cpu_re),
        .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .wr_mask_o(wr_mask)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_mask(input logic [3:0] ctl);
        return ctl[1] ? (8'h03 << (2 * int'(ctl[3:2]))) : 8'hFF;
    endfunction

    function automatic logic [7:0] exp_read(input logic [2:0] ad);
        int c;
        c = int'(ad[2]);
        case (ad[1:0])
            2'd0:    return m_data[c];
            2'd1:    return m_src[c];
            2'd2:    return m_dst[c];
            default: return {m_flag[c], 3'b000, m_ctl[c]};
        endcase
    endfunction

    // drive one cycle, check outputs before the edge, advance the model
    task automatic drive(input logic tk, input logic [4:0] sl, input logic [2:0] ad,
                         input logic we, input logic re, input logic [7:0] wd,
                         input logic [7:0] ra, input logic [7:0] rb);
        @(negedge clk);
        tick = tk; slot = sl; cpu_addr = ad; cpu_we = we; cpu_re = re;
        cpu_wdata = wd; rd_data = {rb, ra};
        #2;
        chk("R8", 32'(cpu_rdata), 32'(exp_read(ad)));
        for (int c = 0; c < 2; c++) begin
            logic hr, hw, mine;
            logic [7:0] m, rdv;
            string tg;
            hr   = tk && m_ctl[c][0] && (m_src[c][4:0] == sl);
            hw   = tk && m_ctl[c][0] && (m_dst[c][4:0] == sl);
            m    = exp_mask(m_ctl[c]);
            rdv  = (c == 0) ? ra : rb;
            mine = (int'(ad[2]) == c);
            tg   = !tk ? "R11" : (!m_ctl[c][0] ? "R6" : "R3");
            chk(tg, 32'(rd_en[c]), 32'(hr));
            chk(tk ? (m_ctl[c][0] ? "R4" : "R6") : "R11", 32'(wr_en[c]), 32'(hw));
            if (hr) chk("R2", 32'(rd_addr[c*8 +: 8]), 32'(m_src[c]));
            if (hw) begin
                chk("R2", 32'(wr_addr[c*8 +: 8]), 32'(m_dst[c]));
                chk("R4", 32'(wr_data[c*8 +: 8]), 32'(m_data[c]));
                chk("R5", 32'(wr_mask[c*8 +: 8]), 32'(m));
            end
            if (hr) begin
                m_data[c] = (m_data[c] & ~m) | (rdv & m);
                m_flag[c] = 1'b1;
            end else begin
                if (we && mine && ad[1:0] == 2'd0) m_data[c] = wd;
                if (re && mine && ad[1:0] == 2'd0) m_flag[c] = 1'b0;
            end
            if (we && mine) begin
                case (ad[1:0])
                    2'd1: m_src[c] = wd;
                    2'd2: m_dst[c] = wd;
                    2'd3: m_ctl[c] = wd[3:0];
                    default: ;
                endcase
            end
        end
    endtask

    task automatic wr(input logic [2:0] ad, input logic [7:0] wd);
        drive(1'b0, 5'd0, ad, 1'b1, 1'b0, wd, 8'h00, 8'h00);
    endtask

    task automatic rd(input logic [2:0] ad);
        drive(1'b0, 5'd0, ad, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 2; c++) begin
            m_data[c] = '0; m_src[c] = '0; m_dst[c] = '0; m_ctl[c] = '0; m_flag[c] = 1'b0;
        end
        rst_n = 1'b0; tick = 1'b0; slot = '0; cpu_addr = '0; cpu_we = 1'b0;
        cpu_re = 1'b0; cpu_wdata = '0; rd_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: all registers zero, no strobes even on a tick at slot 0
        for (int a = 0; a < 8; a++) begin
            rd(3'(a));
            chk("R1", 32'(cpu_rdata), 32'h0);
        end
        drive(1'b1, 5'd0, 3'd0, 1'b0, 1'b0, 8'h00, 8'hAB, 8'hCD);
        chk("R1", 32'({rd_en, wr_en}), 32'h0);

        // channel A: configurable port 2 slot 3 -> PCM port 0 slot 5
        wr(3'd1, 8'hC3); wr(3'd2, 8'h05); wr(3'd3, 8'h01);
        // channel B: loop a configurable slot 7 onto itself
        wr(3'd5, 8'h87); wr(3'd6, 8'h87); wr(3'd7, 8'h01);

        drive(1'b1, 5'd3, 3'd0, 1'b0, 1'b0, 8'h00, 8'h5A, 8'h00);
        chk("R3", 32'(rd_en), 32'h1);
        rd(3'd0); chk("R3", 32'(cpu_rdata), 32'h5A);
        rd(3'd3); chk("R10", 32'(cpu_rdata), 32'h81);
        drive(1'b0, 5'd0, 3'd0, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00);
        rd(3'd3); chk("R10", 32'(cpu_rdata), 32'h01);

        drive(1'b1, 5'd5, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00);
        chk("R4", 32'(wr_data[7:0]), 32'h5A);
        chk("R4", 32'(wr_mask[7:0]), 32'hFF);

        // R4: same-slot read and write on B writes the pre-capture value
        drive(1'b1, 5'd7, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h33);
        chk("R4", 32'(wr_data[15:8]), 32'h00);
        drive(1'b1, 5'd7, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h66);
        chk("R4", 32'(wr_data[15:8]), 32'h33);

        // R9: capture and host buffer write collide; R10: read-clear loses to capture
        drive(1'b1, 5'd3, 3'd0, 1'b1, 1'b1, 8'hEE, 8'h11, 8'h00);
        rd(3'd0); chk("R9", 32'(cpu_rdata), 32'h11);
        rd(3'd3); chk("R10", 32'(cpu_rdata), 32'h81);

        // R5: restrict to sub-slot 2 (bits 5:4)
        wr(3'd3, 8'h0B);
        drive(1'b1, 5'd3, 3'd0, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h00);
        rd(3'd0); chk("R5", 32'(cpu_rdata), 32'h31);
        drive(1'b1, 5'd5, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00);
        chk("R5", 32'(wr_mask[7:0]), 32'h30);

        // R6: disabled channel is silent and keeps its buffer
        wr(3'd3, 8'h00);
        drive(1'b1, 5'd3, 3'd0, 1'b0, 1'b0, 8'h00, 8'h99, 8'h00);
        chk("R6", 32'(rd_en[0]), 32'h0);
        rd(3'd0); chk("R6", 32'(cpu_rdata), 32'h31);

        // R7: both channels capture in one cycle from their own lanes
        wr(3'd3, 8'h01); wr(3'd5, 8'h03);
        drive(1'b1, 5'd3, 3'd0, 1'b0, 1'b0, 8'h00, 8'h44, 8'h55);
        chk("R7", 32'(rd_en), 32'h3);
        rd(3'd4); chk("R7", 32'(cpu_rdata), 32'h55);
        rd(3'd0); chk("R7", 32'(cpu_rdata), 32'h44);

        // R11: no tick, no strobes
        drive(1'b0, 5'd3, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00);
        chk("R11", 32'({rd_en, wr_en}), 32'h0);

        // constrained random traffic, slots mostly in 0..3
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            logic [7:0]  wd;
            logic [4:0]  sl;
            r  = $urandom;
            sl = r[24] ? r[8:4] : {3'b000, r[3:2]};
            wd = (r[10:9] == 2'd1 || r[10:9] == 2'd2) ? {r[23:21], 3'b000, r[16:15]} : r[23:16];
            drive(r[0] | r[1], sl, r[11:9], r[13:12] == 2'd0, r[14], wd,
                  8'($urandom), 8'($urandom));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule